// File: doc/BRIEF.md
# Audio Interface Status and Interrupt Register

This block is the status and interrupt collector for a digital audio serial interface. The transmitter and receiver datapaths send it single-cycle event pulses. The block latches those pulses into sticky flags and gates them through software enables onto four level interrupt lines. Two of the lines are error lines, one for transmit and one for receive. The other two report the state of the user-information holding registers. Software reaches the block through a word-addressed bus with read and write strobes and a 32-bit data path.

The flags do not all clear the same way. The three error flags clear only when software writes 0 to their bit. The receive-user flag clears as a side effect of reading the receive user register. The transmit-user flag clears when software writes the transmit user register. An error interrupt needs two enables set: a group enable for its direction and the flag's own enable.

A channel-status flag marks a channel-status load that arrives too early. The datapath supplies the frame index within the current block, and any load seen before frame index 31 (the 32nd frame) is flagged.

Top module: `aud_stat_irq`

## Requirements
- R1: While reset is held, and after it, the status word reads 0x10 (transmit-user empty set, all else clear), the control word reads 0, and all four interrupt lines are low.
- R2: A channel-status load with frame index below 31 sets status bit 0. A load at frame index 31 or higher leaves the bit unchanged.
- R3: Status bits 0 (channel-status early), 1 (underrun) and 2 (overrun) are sticky. A status write (address 0) with a 0 in such a bit clears it, and a 1 leaves it unchanged.
- R4: A set event in the same cycle as that flag's clearing action leaves the flag set. This holds for all five flags.
- R5: An underrun pulse sets status bit 1 and an overrun pulse sets status bit 2.
- R6: A receive-user load captures the data word and sets status bit 3. The word reads back at address 2. A read strobe at address 2 clears bit 3, and a plain address select without the strobe does not.
- R7: A transmit-user take pulse sets status bit 4. A write to address 3 clears bit 4, stores the word, and drives it on the transmit user data output, where address 3 also reads it back.
- R8: The transmit-error line equals control bit 0 AND ((status bit 0 AND control bit 2) OR (status bit 1 AND control bit 3)).
- R9: The receive-error line equals control bit 1 AND status bit 2 AND control bit 4.
- R10: The receive-user line equals status bit 3 AND control bit 5. The transmit-user line equals status bit 4 AND control bit 6.
- R11: Writes to status bits 3 and 4 have no effect. Status bits 31:5 and control bits 31:7 read 0. Addresses with any bit above bit 1 set read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (triggers read side effects) |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| cs_load_i | input | 1 | Channel-status load pulse |
| frame_idx_i | input | FRAME_W | Current frame index within the block |
| ovr_evt_i | input | 1 | Receive buffer overrun pulse |
| udr_evt_i | input | 1 | Transmit buffer underrun pulse |
| rx_user_load_i | input | 1 | Receive user word valid pulse |
| rx_user_data_i | input | DATA_W | Receive user word |
| tx_user_take_i | input | 1 | Transmit user word consumed pulse |
| tx_user_data_o | output | DATA_W | Transmit user word held for the datapath |
| irq_tx_err_o | output | 1 | Transmit error interrupt |
| irq_rx_err_o | output | 1 | Receive error interrupt |
| irq_rx_user_o | output | 1 | Receive user word present interrupt |
| irq_tx_user_o | output | 1 | Transmit user register empty interrupt |

## Verification
The assertions assume that event inputs and strobes are sampled only at rising edges and are free of X once the synchronised reset has released. They also assume the frame index is meaningful whenever a channel-status load is asserted. The stimulus respects both: every input changes on the falling edge, pulses last exactly one cycle, and the frame index is set in the same falling edge as its load. The deliberate collisions between a set event and a clearing action are driven in one cycle, so the set-priority properties are exercised.

// File: rtl/aud_stat_pkg.sv
package aud_stat_pkg;
  // status bit positions
  localparam int unsigned SB_CS_EARLY = 0;
  localparam int unsigned SB_UDR      = 1;
  localparam int unsigned SB_OVR      = 2;
  localparam int unsigned SB_RX_FULL  = 3;
  localparam int unsigned SB_TX_EMPTY = 4;
  localparam int unsigned NFLAG       = 5;
  localparam int unsigned NSTICKY     = 3;

  // control bit positions
  localparam int unsigned EN_TX_GRP   = 0;
  localparam int unsigned EN_RX_GRP   = 1;
  localparam int unsigned EN_CS_EARLY = 2;
  localparam int unsigned EN_UDR      = 3;
  localparam int unsigned EN_OVR      = 4;
  localparam int unsigned EN_RX_FULL  = 5;
  localparam int unsigned EN_TX_EMPTY = 6;
  localparam int unsigned CTRL_W      = 7;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_CTRL = 2'd1,
    REG_RXU  = 2'd2,
    REG_TXU  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/aud_rst_sync.sv
module aud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/aud_evt_flag.sv
module aud_evt_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) q_o <= RST_VAL;
    else         q_o <= q_d;
  end

  // a set event is never lost to a concurrent clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    set_i |=> q_o);

  // clearing action alone empties the flag (R3, R6, R7)
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (clr_i && !set_i) |=> !q_o);

  // without any action the flag is sticky
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/aud_irq_gate.sv
module aud_irq_gate
  import aud_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [NFLAG-1:0]  flag_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              irq_tx_err_o,
  output logic              irq_rx_err_o,
  output logic              irq_rx_user_o,
  output logic              irq_tx_user_o
);
  logic tx_pend;

  always_comb begin
    tx_pend       = (flag_i[SB_CS_EARLY] & ctrl_i[EN_CS_EARLY])
                  | (flag_i[SB_UDR]      & ctrl_i[EN_UDR]);
    irq_tx_err_o  = ctrl_i[EN_TX_GRP] & tx_pend;
    irq_rx_err_o  = ctrl_i[EN_RX_GRP] & flag_i[SB_OVR] & ctrl_i[EN_OVR];
    irq_rx_user_o = flag_i[SB_RX_FULL]  & ctrl_i[EN_RX_FULL];
    irq_tx_user_o = flag_i[SB_TX_EMPTY] & ctrl_i[EN_TX_EMPTY];
  end

  p_tx_group_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_tx_err_o |-> (ctrl_i[EN_TX_GRP] && (flag_i[SB_CS_EARLY] || flag_i[SB_UDR])));

  p_rx_group_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_rx_err_o |-> (ctrl_i[EN_RX_GRP] && flag_i[SB_OVR]));

  p_user_lines_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq_rx_user_o |-> flag_i[SB_RX_FULL]) and (irq_tx_user_o |-> flag_i[SB_TX_EMPTY]));
endmodule

// File: rtl/aud_stat_irq.sv
module aud_stat_irq
  import aud_stat_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FRAME_W  = 8,
  parameter int unsigned CS_LIMIT = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               cs_load_i,
  input  logic [FRAME_W-1:0] frame_idx_i,
  input  logic               ovr_evt_i,
  input  logic               udr_evt_i,
  input  logic               rx_user_load_i,
  input  logic [DATA_W-1:0]  rx_user_data_i,
  input  logic               tx_user_take_i,
  output logic [DATA_W-1:0]  tx_user_data_o,
  output logic               irq_tx_err_o,
  output logic               irq_rx_err_o,
  output logic               irq_rx_user_o,
  output logic               irq_tx_user_o
);
  localparam int unsigned SEL_W = 2;
  localparam logic [FRAME_W-1:0] CS_LIM_V = FRAME_W'(CS_LIMIT);

  logic              rst_sn;
  logic              hit;
  reg_sel_e          sel;
  logic              wr_stat, wr_ctrl, wr_txu, rd_rxu;
  logic [NFLAG-1:0]  flag_set, flag_clr, flag_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rxu_q, rxu_d, txu_q, txu_d;

  aud_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // address decode
  always_comb begin
    hit     = (bus_addr_i[ADDR_W-1:SEL_W] == '0);
    sel     = reg_sel_e'(bus_addr_i[SEL_W-1:0]);
    wr_stat = bus_wr_i & hit & (sel == REG_STAT);
    wr_ctrl = bus_wr_i & hit & (sel == REG_CTRL);
    wr_txu  = bus_wr_i & hit & (sel == REG_TXU);
    rd_rxu  = bus_rd_i & hit & (sel == REG_RXU);
  end

  // flag set and clear sources
  always_comb begin
    flag_set                 = '0;
    flag_set[SB_CS_EARLY]    = cs_load_i & (frame_idx_i < CS_LIM_V);
    flag_set[SB_UDR]         = udr_evt_i;
    flag_set[SB_OVR]         = ovr_evt_i;
    flag_set[SB_RX_FULL]     = rx_user_load_i;
    flag_set[SB_TX_EMPTY]    = tx_user_take_i;
    flag_clr                 = '0;
    for (int i = 0; i < int'(NSTICKY); i++) begin
      flag_clr[i] = wr_stat & ~bus_wdata_i[i];
    end
    flag_clr[SB_RX_FULL]     = rd_rxu;
    flag_clr[SB_TX_EMPTY]    = wr_txu;
  end

  for (genvar g = 0; g < int'(NFLAG); g++) begin : g_flag
    aud_evt_flag #(.RST_VAL(g == int'(SB_TX_EMPTY))) u_flag (
      .clk    (clk),
      .rst_sn (rst_sn),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  // control and user holding registers: next state
  always_comb begin
    ctrl_d = wr_ctrl        ? bus_wdata_i[CTRL_W-1:0] : ctrl_q;
    rxu_d  = rx_user_load_i ? rx_user_data_i          : rxu_q;
    txu_d  = wr_txu         ? bus_wdata_i             : txu_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      rxu_q  <= '0;
      txu_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rxu_q  <= rxu_d;
      txu_q  <= txu_d;
    end
  end

  assign tx_user_data_o = txu_q;

  // readback
  always_comb begin
    bus_rdata_o = '0;
    if (hit) begin
      unique case (sel)
        REG_STAT: bus_rdata_o[NFLAG-1:0]  = flag_q;
        REG_CTRL: bus_rdata_o[CTRL_W-1:0] = ctrl_q;
        REG_RXU:  bus_rdata_o             = rxu_q;
        REG_TXU:  bus_rdata_o             = txu_q;
        default:  bus_rdata_o             = '0;
      endcase
    end
  end

  aud_irq_gate u_gate (
    .clk           (clk),
    .rst_sn        (rst_sn),
    .flag_i        (flag_q),
    .ctrl_i        (ctrl_q),
    .irq_tx_err_o  (irq_tx_err_o),
    .irq_rx_err_o  (irq_rx_err_o),
    .irq_rx_user_o (irq_rx_user_o),
    .irq_tx_user_o (irq_tx_user_o)
  );

  p_cs_early_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (cs_load_i && (frame_idx_i < CS_LIM_V)) |=> flag_q[SB_CS_EARLY]);

  p_cs_late_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (cs_load_i && (frame_idx_i >= CS_LIM_V) && !flag_q[SB_CS_EARLY]) |=> !flag_q[SB_CS_EARLY]);

  p_txu_store_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_txu |=> (tx_user_data_o == $past(bus_wdata_i)));

  p_rxu_capture_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_user_load_i |=> (rxu_q == $past(rx_user_data_i)));
endmodule

// File: tb/aud_stat_irq_test.sv
`timescale 1ns/1ps
module aud_stat_irq_test;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          cs_load;
  logic [FW-1:0] frame_idx;
  logic          ovr_evt, udr_evt, rx_load, tx_take;
  logic [DW-1:0] rx_data, tx_data;
  logic          irq_tx_err, irq_rx_err, irq_rx_user, irq_tx_user;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd_v;

  always #2 clk = ~clk;

  aud_stat_irq #(.ADDR_W(AW), .DATA_W(DW), .FRAME_W(FW), .CS_LIMIT(31)) uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cs_load_i(cs_load), .frame_idx_i(frame_idx),
    .ovr_evt_i(ovr_evt), .udr_evt_i(udr_evt),
    .rx_user_load_i(rx_load), .rx_user_data_i(rx_data),
    .tx_user_take_i(tx_take), .tx_user_data_o(tx_data),
    .irq_tx_err_o(irq_tx_err), .irq_rx_err_o(irq_rx_err),
    .irq_rx_user_o(irq_rx_user), .irq_tx_user_o(irq_tx_user)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_strobe(input logic [AW-1:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pulse_cs(input int f);
    @(negedge clk);
    cs_load = 1'b1; frame_idx = FW'(f);
    @(negedge clk);
    cs_load = 1'b0;
  endtask

  task automatic pulse_ev(input logic u, input logic o, input logic rl, input logic tt);
    @(negedge clk);
    udr_evt = u; ovr_evt = o; rx_load = rl; tx_take = tt;
    @(negedge clk);
    udr_evt = 1'b0; ovr_evt = 1'b0; rx_load = 1'b0; tx_take = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    cs_load = 0; frame_idx = '0; ovr_evt = 0; udr_evt = 0;
    rx_load = 0; rx_data = '0; tx_take = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    peek(0, rd_v); check("R1 status in reset", rd_v, 32'h10);
    check("R1 irq in reset", {28'd0, irq_tx_err, irq_rx_err, irq_rx_user, irq_tx_user}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    peek(0, rd_v); check("R1 status after reset", rd_v, 32'h10);
    peek(1, rd_v); check("R1 control after reset", rd_v, 32'h0);
    check("R1 irq after reset", {28'd0, irq_tx_err, irq_rx_err, irq_rx_user, irq_tx_user}, 32'd0);

    // R2 frame sweep
    for (int f = 0; f < 192; f++) begin
      wr(0, 32'h0);
      pulse_cs(f);
      peek(0, rd_v);
      check($sformatf("R2 cs early frame %0d", f), {31'd0, rd_v[0]}, {31'd0, (f < 31)});
    end

    // R5 event sources
    wr(0, 32'h0);
    pulse_ev(1, 0, 0, 0);
    peek(0, rd_v); check("R5 underrun sets bit1", rd_v & 32'h7, 32'h2);
    pulse_ev(0, 1, 0, 0);
    peek(0, rd_v); check("R5 overrun sets bit2", rd_v & 32'h7, 32'h6);

    // R3 write-one keeps, write-zero clears selectively
    pulse_cs(0);
    wr(0, 32'hFFFF_FFFF);
    peek(0, rd_v); check("R3 write ones keeps", rd_v & 32'h7, 32'h7);
    wr(0, 32'hFFFF_FFFD);
    peek(0, rd_v); check("R3 clear underrun only", rd_v & 32'h7, 32'h5);
    wr(0, 32'hFFFF_FFFA);
    peek(0, rd_v); check("R3 clear remaining", rd_v & 32'h7, 32'h0);

    // R4 set wins over concurrent write-zero
    @(negedge clk);
    bus_wr = 1; bus_addr = 0; bus_wdata = 0; udr_evt = 1;
    @(negedge clk);
    bus_wr = 0; udr_evt = 0;
    peek(0, rd_v); check("R4 underrun vs clear", rd_v & 32'h7, 32'h2);

    // R6 receive user word
    pulse_ev(0, 0, 1, 0);
    rx_data = 32'h0;
    @(negedge clk);
    rx_data = 32'hA5A5_1234;
    pulse_ev(0, 0, 1, 0);
    peek(2, rd_v); check("R6 rx word readback", rd_v, 32'hA5A5_1234);
    peek(0, rd_v); check("R6 full after plain select", {31'd0, rd_v[3]}, 32'd1);
    rd_strobe(2);
    peek(0, rd_v); check("R6 full cleared by read", {31'd0, rd_v[3]}, 32'd0);
    @(negedge clk);
    bus_rd = 1; bus_addr = 2; rx_load = 1;
    @(negedge clk);
    bus_rd = 0; rx_load = 0;
    peek(0, rd_v); check("R4 rx load vs read", {31'd0, rd_v[3]}, 32'd1);

    // R7 transmit user word
    wr(3, 32'h0000_CAFE);
    check("R7 tx word output", tx_data, 32'h0000_CAFE);
    peek(3, rd_v); check("R7 tx word readback", rd_v, 32'h0000_CAFE);
    peek(0, rd_v); check("R7 empty cleared by write", {31'd0, rd_v[4]}, 32'd0);
    pulse_ev(0, 0, 0, 1);
    peek(0, rd_v); check("R7 empty set by take", {31'd0, rd_v[4]}, 32'd1);
    @(negedge clk);
    bus_wr = 1; bus_addr = 3; bus_wdata = 32'h1; tx_take = 1;
    @(negedge clk);
    bus_wr = 0; tx_take = 0;
    peek(0, rd_v); check("R4 take vs write", {31'd0, rd_v[4]}, 32'd1);

    // R11 read-only and unused bits
    wr(0, 32'h0);
    peek(0, rd_v); check("R11 ro bits ignore write", rd_v, 32'h18);
    wr(1, 32'hFFFF_FFFF);
    peek(1, rd_v); check("R11 control width", rd_v, 32'h7F);
    wr(5, 32'h0);
    peek(1, rd_v); check("R11 out-of-range write ignored", rd_v, 32'h7F);
    peek(5, rd_v); check("R11 out-of-range read zero", rd_v, 32'h0);

    // R8 R9 R10 exhaustive gating sweep
    for (int m = 0; m < 32; m++) begin
      wr(0, 32'h0);
      rd_strobe(2);
      wr(3, 32'h0);
      if (m[0]) pulse_cs(5);
      pulse_ev(m[1], m[2], m[3], m[4]);
      peek(0, rd_v);
      check($sformatf("R8 flag setup %0d", m), rd_v, 32'(m));
      for (int c = 0; c < 128; c++) begin
        logic e_tx, e_rx, e_ru, e_tu;
        wr(1, 32'(c));
        e_tx = c[0] & ((m[0] & c[2]) | (m[1] & c[3]));
        e_rx = c[1] & m[2] & c[4];
        e_ru = m[3] & c[5];
        e_tu = m[4] & c[6];
        check($sformatf("R8 tx err m=%0d c=%0d", m, c), {31'd0, irq_tx_err}, {31'd0, e_tx});
        check($sformatf("R9 rx err m=%0d c=%0d", m, c), {31'd0, irq_rx_err}, {31'd0, e_rx});
        check($sformatf("R10 user m=%0d c=%0d", m, c), {30'd0, irq_rx_user, irq_tx_user}, {30'd0, e_ru, e_tu});
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule